// File: doc/BRIEF.md
# Serial GF(2) Polynomial Remainder Unit

This block divides a bit stream, taken as a polynomial over GF(2), by a fixed generator polynomial of degree five. It uses the Galois arrangement of a linear feedback shift register: XOR gates sit between register stages, and the register carries out the long division itself. Dividend coefficients arrive one per clock, highest-order term first. After as many accepted bits as the dividend has, the register stages hold the remainder. The remainder is presented in parallel, with the highest stage as the most significant bit.

A user clears the unit synchronously, streams the dividend with a valid strobe, and then reads the remainder. Cycles with the strobe low leave the division paused. The generator is a parameter: a tap mask gives the coefficients of x^0..x^4, and the x^5 term is implied. The default generator is x^5 + x^3 + x^2 + 1.

Top module: `gf2SerialRem`

## Requirements
- R1: With `clearSync` high at a rising edge, all stages are zero after that edge, so `remainder` reads 5'b00000.
- R2: When `clearSync` and `dataValid` are both high at the same edge, the clear wins and the input bit is discarded.
- R3: With `clearSync` and `dataValid` both low at an edge, `remainder` keeps its value.
- R4: An accepted bit with `remainder[4]` low moves bits [3:0] up to [4:1] and loads the input bit into bit 0.
- R5: An accepted bit with `remainder[4]` high gives a new value equal to the plain shift of R4 XOR the tap mask, which is 5'b01101 by default (taps at bits 0, 2 and 3, for x^0, x^2 and x^3).
- R6: After a clear, the dividend 11001110 (left bit first) leaves `remainder` (bit 4 down to bit 0) at 00001, 00011, 00110, 01100, 11001, 11110, 10000 and 01101 after each accepted bit in turn.
- R7: For any dividend of N bits fed after a clear, `remainder` equals that dividend modulo x^5 + x^3 + x^2 + 1 once the N-th bit is accepted, and at every intermediate point it equals the remainder of the prefix accepted so far.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clearSync | input | 1 | Synchronous clear of all stages; wins over data |
| dataValid | input | 1 | Accepts `dataBit` at this edge |
| dataBit | input | 1 | Next dividend coefficient, highest-order first |
| remainder | output | 5 | Register stages; bit 4 is the highest stage |

## Verification
The assertions assume that `clearSync` has been asserted at least once before anything else about the state is assumed. Until then the stages hold no defined value, so every property stays disabled until the first clear. They also assume that the control inputs are never unknown at a clock edge. The stimulus drives all inputs to known levels from time zero, and it opens with a clear before any data or hold cycles. It then mixes random dividend lengths with idle cycles and with clears that collide with valid bits.

// File: rtl/gf2rem_pkg.sv
package gf2rem_pkg;
  // Strobes from control to datapath: at most one is high in a cycle.
  typedef struct packed {
    logic clear;
    logic shift;
  } remStrobe_t;
endpackage

// File: rtl/gf2RemCtrl.sv
module gf2RemCtrl
  import gf2rem_pkg::*;
(
  input  logic       clearSync,
  input  logic       dataValid,
  output remStrobe_t strobe
);
  // Clear takes precedence; a valid bit in a clear cycle is dropped.
  always_comb begin
    strobe.clear = clearSync;
    strobe.shift = dataValid & ~clearSync;
  end
endmodule

// File: rtl/gf2RemDatapath.sv
module gf2RemDatapath
  import gf2rem_pkg::*;
#(
  parameter int                DEGREE   = 5,
  parameter logic [DEGREE-1:0] TAP_MASK = 5'b01101
) (
  input  logic              clk,
  input  remStrobe_t        strobe,
  input  logic              serialIn,
  output logic [DEGREE-1:0] stateOut
);
  localparam int TOP = DEGREE - 1;

  logic [DEGREE-1:0] stateQ;
  logic [DEGREE-1:0] nextD;
  logic              feedback;

  // Leading coefficient: when set, the generator is subtracted this step.
  assign feedback = stateQ[TOP];

  for (genvar i = 0; i < DEGREE; i++) begin : g_stage
    logic shiftSrc;
    if (i == 0) begin : g_head
      assign shiftSrc = serialIn;
    end else begin : g_chain
      assign shiftSrc = stateQ[i-1];
    end
    if (TAP_MASK[i]) begin : g_tap
      assign nextD[i] = shiftSrc ^ feedback;
    end else begin : g_plain
      assign nextD[i] = shiftSrc;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.clear)      stateQ <= '0;
    else if (strobe.shift) stateQ <= nextD;
  end

  assign stateOut = stateQ;

  // Checking aid: the stages are undefined until the first clear.
  logic armedQ = 1'b0;
  always_ff @(posedge clk) begin
    if (strobe.clear) armedQ <= 1'b1;
  end

  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!armedQ)
    strobe.clear |=> (stateQ == '0));

  p_clear_wins_r2: assert property (@(posedge clk) disable iff (!armedQ)
    strobe.clear |-> !strobe.shift);

  p_hold_r3: assert property (@(posedge clk) disable iff (!armedQ)
    (!strobe.clear && !strobe.shift) |=> $stable(stateQ));

  p_step_plain_r4: assert property (@(posedge clk) disable iff (!armedQ)
    (strobe.shift && !stateQ[TOP])
      |=> (stateQ == {$past(stateQ[TOP-1:0]), $past(serialIn)}));

  p_step_sub_r5: assert property (@(posedge clk) disable iff (!armedQ)
    (strobe.shift && stateQ[TOP])
      |=> ((stateQ ^ {$past(stateQ[TOP-1:0]), $past(serialIn)}) == TAP_MASK));
endmodule

// File: rtl/gf2SerialRem.sv
module gf2SerialRem
  import gf2rem_pkg::*;
#(
  parameter int                DEGREE   = 5,
  parameter logic [DEGREE-1:0] TAP_MASK = 5'b01101
) (
  input  logic              clk,
  input  logic              clearSync,
  input  logic              dataValid,
  input  logic              dataBit,
  output logic [DEGREE-1:0] remainder
);
  remStrobe_t strobe;

  gf2RemCtrl u_ctrl (
    .clearSync (clearSync),
    .dataValid (dataValid),
    .strobe    (strobe)
  );

  gf2RemDatapath #(
    .DEGREE   (DEGREE),
    .TAP_MASK (TAP_MASK)
  ) u_dp (
    .clk      (clk),
    .strobe   (strobe),
    .serialIn (dataBit),
    .stateOut (remainder)
  );
endmodule

// File: tb/gf2SerialRem_bench.sv
module gf2SerialRem_bench;
  localparam logic [5:0] GEN = 6'b101101;  // x^5 + x^3 + x^2 + 1

  logic clk = 1'b0;
  logic clearSync = 1'b0;
  logic dataValid = 1'b0;
  logic dataBit = 1'b0;
  logic [4:0] remainder;

  always #4 clk = ~clk;  // 125 MHz

  gf2SerialRem u_gf2SerialRem (
    .clk       (clk),
    .clearSync (clearSync),
    .dataValid (dataValid),
    .dataBit   (dataBit),
    .remainder (remainder)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [4:0] expQ[$];
  string      tagQ[$];

  logic [63:0] divQ = '0;
  int          lenQ = 0;
  logic [4:0]  modelRem = '0;

  // Textbook long division: cancel the leading term from the top down.
  function automatic logic [4:0] longDiv(logic [63:0] d, int n);
    for (int i = n - 1; i >= 5; i--)
      if (d[i]) d = d ^ (64'(GEN) << (i - 5));
    return d[4:0];
  endfunction

  // Driver: one cycle of stimulus, with the expected result pushed to the scoreboard.
  task automatic cycle(input logic clr, input logic vld, input logic b,
                       input bit useExp, input logic [4:0] expv, input string req);
    @(negedge clk);
    clearSync = clr;
    dataValid = vld;
    dataBit   = b;
    if (clr) begin
      divQ = '0; lenQ = 0; modelRem = '0;
    end else if (vld) begin
      divQ = {divQ[62:0], b}; lenQ++;
      modelRem = longDiv(divQ, lenQ);
    end
    expQ.push_back(useExp ? expv : modelRem);
    tagQ.push_back(req);
  endtask

  // Monitor: sample shortly after each edge, when the result is settled.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        logic [4:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (remainder !== e) begin
          errors++;
          $display("FAIL %s: remainder=%b expected=%b", t, remainder, e);
        end
      end
    end
  end

  initial begin
    logic [7:0] example;
    logic [4:0] trace [8];
    example = 8'b11001110;
    trace = '{5'b00001, 5'b00011, 5'b00110, 5'b01100,
              5'b11001, 5'b11110, 5'b10000, 5'b01101};

    // R1: clear from power-up
    cycle(1, 0, 0, 0, '0, "R1");
    cycle(0, 0, 0, 0, '0, "R3");

    // R6: worked example, state after each bit
    for (int i = 7; i >= 0; i--)
      cycle(0, 1, example[i], 1, trace[7 - i], "R6");
    // R3: idle cycles keep the final remainder
    cycle(0, 0, 1, 1, 5'b01101, "R3");
    cycle(0, 0, 0, 1, 5'b01101, "R3");

    // R2: clear with a valid one bit pending
    cycle(1, 1, 1, 1, 5'b00000, "R2");
    // R4: leading bit low, plain shift
    cycle(0, 1, 1, 1, 5'b00001, "R4");
    cycle(0, 1, 0, 1, 5'b00010, "R4");
    cycle(0, 1, 1, 1, 5'b00101, "R4");
    cycle(0, 1, 1, 1, 5'b01011, "R4");
    cycle(0, 1, 0, 1, 5'b10110, "R4");
    // R5: leading bit high, 01100 ^ 01101
    cycle(0, 1, 0, 1, 5'b00001, "R5");
    // R2: clear mid-stream, then R1 zero check
    cycle(1, 1, 0, 1, 5'b00000, "R2");
    // R5: all ones into cleared register
    for (int i = 0; i < 6; i++) cycle(0, 1, 1, 0, '0, "R5");

    // R7: random dividends of varied lengths, with idle gaps
    for (int run = 0; run < 40; run++) begin
      int n;
      n = 1 + int'($urandom_range(59));
      cycle(1, $urandom_range(1), $urandom_range(1), 0, '0, "R1");
      for (int k = 0; k < n; k++) begin
        if ($urandom_range(3) == 0) cycle(0, 0, $urandom_range(1), 0, '0, "R3");
        cycle(0, 1, $urandom_range(1), 0, '0, "R7");
      end
    end

    while (expQ.size() > 0) @(posedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule